// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 32 interrupt sources and presents one active-low request line to a processor. Each source has its own control register. That register chooses how the source input is recognised: low level, high level, falling edge or rising edge. It also holds a 3-bit priority. Edge events are held in per-source pending latches. Level sources are pending for as long as their input holds the active level. Software enables and disables sources through separate command registers for mask set and mask clear. It can also force or cancel a pending latch.

When the request line is low, the handler reads the vector register. The value returned is the winning source number times four, ready for use as a table offset. That read releases the request line and clears the winner's edge latch. The line stays quiet until software writes the end-of-service register. After that write, arbitration may raise the line again for whatever is still pending. Bus reads are combinational; bus writes and read side effects take place at the clock edge of the access.

Top module: `vic_top`

## Requirements
- R1: After reset the request output `irqN` is high, the enable register (0x114) reads 0, and every source control register reads 0.
- R2: The control register of source n sits at byte offset 4*n. Bits 7:6 hold the trigger type and bits 2:0 hold the priority, with values 0 to 7 all accepted. The other bits are not stored and read as 0.
- R3: Type 0 marks the source pending while its input is 0, and type 1 while its input is 1. The pending register at 0x108 (one bit per source, bit n = source n) follows the input, sampled by one register.
- R4: Type 2 latches a pending bit on a 1-to-0 input transition, and type 3 on a 0-to-1 transition. The bit stays set after the input returns.
- R5: A write to 0x120 enables the sources whose data bits are 1. A write to 0x124 disables them. 0x114 reads 1 for each enabled source. 0x104 reads pending AND enabled. Writing all ones to 0x124 disables every source at once but leaves pending bits as they are.
- R6: `irqN` goes low within three cycles once some source is both pending and enabled and no service is open. It stays high when nothing is active.
- R7: A read of 0x10C returns 4 times the index of the winning source. The winner is the pending, enabled source with the smallest priority value; on a tie, the lowest index wins. The read returns 0 when no source is active. 0x110 then reads the winner's index.
- R8: A read of 0x10C opens a service. `irqN` is high from the next cycle and stays high until any write to 0x130 closes the service.
- R9: A read of 0x10C clears the pending latch of the source it returned.
- R10: A write to 0x128 sets the pending latches of the sources whose data bits are 1. A write to 0x12C clears them.
- R11: 0x100 reads the sampled source inputs. Bit 0 of 0x118 reads 1 while `irqN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access valid this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 9 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| srcIn | input | 32 | Interrupt source inputs |
| irqN | output | 1 | Interrupt request to the processor, active low |

## Verification
The assertions assume that at most one bus access happens per cycle. Under that assumption, a vector read, a command write and an end-of-service write never share an edge, so exactly one command strobe is decoded per cycle. They also assume that source inputs change only between clock edges. The bench drives every bus access and every source change at the falling clock edge, one access at a time. Each input change is held for several cycles, so that the sampling register and the edge detector see every transition.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  // register byte offsets
  localparam int OFF_RAW    = 'h100;
  localparam int OFF_ACTIVE = 'h104;
  localparam int OFF_PEND   = 'h108;
  localparam int OFF_VECTOR = 'h10C;
  localparam int OFF_CURSRC = 'h110;
  localparam int OFF_ENABLE = 'h114;
  localparam int OFF_OUTSTS = 'h118;
  localparam int OFF_ENSET  = 'h120;
  localparam int OFF_ENCLR  = 'h124;
  localparam int OFF_PSET   = 'h128;
  localparam int OFF_PCLR   = 'h12C;
  localparam int OFF_EOS    = 'h130;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic cfgWr;
    logic maskSet;
    logic maskClr;
    logic latchSet;
    logic latchClr;
    logic vecRd;
    logic eosWr;
  } vic_strobe_t;

endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRI_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       actVec,
  input  logic [NUM_SRC*PRI_W-1:0] priFlat,
  output logic [IDX_W-1:0]         winIdx,
  output logic                     anyActive
);

  logic [PRI_W-1:0] bestPri;

  // strict less-than while scanning upward keeps the lowest index on ties
  always_comb begin
    winIdx    = '0;
    bestPri   = '1;
    anyActive = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (actVec[i] && (!anyActive || priFlat[i*PRI_W +: PRI_W] < bestPri)) begin
        anyActive = 1'b1;
        bestPri   = priFlat[i*PRI_W +: PRI_W];
        winIdx    = IDX_W'(i);
      end
    end
  end

  AST_WINNER_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    anyActive |-> actVec[winIdx]); // R7

  AST_NONE_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (actVec == '0) |-> (!anyActive && winIdx == '0)); // R7

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 9,
  localparam int SEL_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              anyActive,
  output vic_strobe_t       strobe,
  output logic              irqActive,
  output logic              irqN
);

  logic wrEn;
  logic rdEn;
  logic inService;
  logic serviceNext;
  logic irqQ;

  assign wrEn = busSel && busWe;
  assign rdEn = busSel && !busWe;

  always_comb begin
    strobe.cfgWr    = wrEn && !busAddr[ADDR_W-1] && (busAddr[1:0] == 2'b00)
                      && (int'(busAddr[ADDR_W-2:2]) < NUM_SRC);
    strobe.maskSet  = wrEn && (busAddr == ADDR_W'(OFF_ENSET));
    strobe.maskClr  = wrEn && (busAddr == ADDR_W'(OFF_ENCLR));
    strobe.latchSet = wrEn && (busAddr == ADDR_W'(OFF_PSET));
    strobe.latchClr = wrEn && (busAddr == ADDR_W'(OFF_PCLR));
    strobe.eosWr    = wrEn && (busAddr == ADDR_W'(OFF_EOS));
    strobe.vecRd    = rdEn && (busAddr == ADDR_W'(OFF_VECTOR));
  end

  always_comb begin
    serviceNext = inService;
    if (strobe.vecRd)      serviceNext = 1'b1;
    else if (strobe.eosWr) serviceNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      inService <= serviceNext;
      irqQ      <= anyActive && !serviceNext;
    end
  end

  assign irqActive = irqQ;
  assign irqN      = !irqQ;

  AST_QUIET_IN_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> irqN); // R8

  AST_VECTOR_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.vecRd |=> irqN); // R8

  AST_REQUEST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(anyActive)); // R6

  AST_EOS_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eosWr |=> !inService); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R5

endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRI_W   = 3,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int SEL_W  = ADDR_W - 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  vic_strobe_t              strobe,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  input  logic [NUM_SRC-1:0]       srcIn,
  input  logic                     irqActive,
  input  logic [IDX_W-1:0]         winIdx,
  input  logic                     anyActive,
  output logic [NUM_SRC-1:0]       actVec,
  output logic [NUM_SRC*PRI_W-1:0] priFlat,
  output logic [DATA_W-1:0]        busRdata
);

  trig_e              trigType [NUM_SRC];
  logic [PRI_W-1:0]   srcPri   [NUM_SRC];
  logic [NUM_SRC-1:0] srcQ;
  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] edgeLatch;
  logic [NUM_SRC-1:0] maskEn;
  logic [IDX_W-1:0]   curSrc;

  logic [NUM_SRC-1:0] edgeHit;
  logic [NUM_SRC-1:0] levelAct;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] vecClr;
  logic [NUM_SRC-1:0] latchNext;
  logic [NUM_SRC-1:0] cmdBits;
  logic [SEL_W-1:0]   cfgSel;

  assign cmdBits = busWdata[NUM_SRC-1:0];
  assign cfgSel  = busAddr[ADDR_W-1:2];

  // input sampling and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ    <= '0;
      srcPrev <= '0;
    end else begin
      srcQ    <= srcIn;
      srcPrev <= srcQ;
    end
  end

  // per-source conditioning
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cond
    assign edgeHit[g]  = ((trigType[g] == TRIG_RISE) &&  srcQ[g] && !srcPrev[g]) ||
                         ((trigType[g] == TRIG_FALL) && !srcQ[g] &&  srcPrev[g]);
    assign levelAct[g] = ((trigType[g] == TRIG_HIGH) &&  srcQ[g]) ||
                         ((trigType[g] == TRIG_LOW)  && !srcQ[g]);
    assign vecClr[g]   = strobe.vecRd && anyActive && (winIdx == IDX_W'(g));
    assign priFlat[g*PRI_W +: PRI_W] = srcPri[g];
  end

  assign pendVec = edgeLatch | levelAct;
  assign actVec  = pendVec & maskEn;

  // clears first, then sets, so a fresh edge is never lost
  always_comb begin
    latchNext = edgeLatch & ~vecClr;
    if (strobe.latchClr) latchNext = latchNext & ~cmdBits;
    if (strobe.latchSet) latchNext = latchNext | cmdBits;
    latchNext = latchNext | edgeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeLatch <= '0;
      maskEn    <= '0;
      curSrc    <= '0;
    end else begin
      edgeLatch <= latchNext;
      if (strobe.maskSet) maskEn <= maskEn | cmdBits;
      if (strobe.maskClr) maskEn <= maskEn & ~cmdBits;
      if (strobe.vecRd)   curSrc <= anyActive ? winIdx : '0;
    end
  end

  // per-source control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        trigType[i] <= TRIG_LOW;
        srcPri[i]   <= '0;
      end
    end else if (strobe.cfgWr) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cfgSel == SEL_W'(i)) begin
          trigType[i] <= trig_e'(busWdata[7:6]);
          srcPri[i]   <= busWdata[PRI_W-1:0];
        end
      end
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (!busAddr[ADDR_W-1]) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cfgSel == SEL_W'(i) && busAddr[1:0] == 2'b00) begin
          busRdata[7:6]       = trigType[i];
          busRdata[PRI_W-1:0] = srcPri[i];
        end
      end
    end else begin
      case (int'(busAddr))
        OFF_RAW:    busRdata[NUM_SRC-1:0] = srcQ;
        OFF_ACTIVE: busRdata[NUM_SRC-1:0] = actVec;
        OFF_PEND:   busRdata[NUM_SRC-1:0] = pendVec;
        OFF_VECTOR: if (anyActive) busRdata[IDX_W+1:0] = {winIdx, 2'b00};
        OFF_CURSRC: busRdata[IDX_W-1:0] = curSrc;
        OFF_ENABLE: busRdata[NUM_SRC-1:0] = maskEn;
        OFF_OUTSTS: busRdata[0] = irqActive;
        default:    busRdata = '0;
      endcase
    end
  end

  AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskClr && cmdBits == '1) |=> (maskEn == '0)); // R5

  AST_CUR_IS_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.vecRd && anyActive) |=> (curSrc == $past(winIdx))); // R7

  AST_MASKED_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (maskEn == '0) |-> !anyActive); // R5

  AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchSet |=> ((edgeLatch & $past(cmdBits)) == $past(cmdBits))); // R10

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRI_W   = 3,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqN
);

  vic_strobe_t              strobe;
  logic                     irqActive;
  logic                     anyActive;
  logic [IDX_W-1:0]         winIdx;
  logic [NUM_SRC-1:0]       actVec;
  logic [NUM_SRC*PRI_W-1:0] priFlat;

  vic_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .anyActive(anyActive), .strobe(strobe), .irqActive(irqActive), .irqN(irqN)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr), .busWdata(busWdata),
    .srcIn(srcIn), .irqActive(irqActive), .winIdx(winIdx), .anyActive(anyActive),
    .actVec(actVec), .priFlat(priFlat), .busRdata(busRdata)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W)) i_arb (
    .clk(clk), .rstN(rstN), .actVec(actVec), .priFlat(priFlat),
    .winIdx(winIdx), .anyActive(anyActive)
  );

endmodule

// File: tb/test_vic_top.sv
module test_vic_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcIn = 32'hFFFF_FFFF;
  logic        irqN;

  int total = 0;
  int bad = 0;

  always #2 clk = !clk;

  vic_top i_vic_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn), .irqN(irqN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 irqN after reset", {31'b0, irqN}, 32'd1);
    readCheck("R1 enable reg", 9'h114, 32'h0);
    readCheck("R1 ctrl reg src5", 9'h014, 32'h0);
    readCheck("R3 no pending with high inputs on low type", 9'h108, 32'h0);
    readCheck("R11 out status idle", 9'h118, 32'h0);
  endtask

  task automatic t_config;
    busWrite(9'h014, 32'h47);
    readCheck("R2 src5 readback pri7", 9'h014, 32'h47);
    busWrite(9'h07C, 32'h86);
    readCheck("R2 src31 readback", 9'h07C, 32'h86);
    busWrite(9'h000, 32'hFF);
    readCheck("R2 unused bits read zero", 9'h000, 32'hC7);
    busWrite(9'h000, 32'h00);
  endtask

  task automatic t_level;
    srcIn[5] = 1'b0; idle(3);
    readCheck("R3 high level inactive", 9'h108, 32'h0);
    srcIn[5] = 1'b1; idle(3);
    readCheck("R3 high level pending", 9'h108, 32'h20);
    srcIn[5] = 1'b0; srcIn[6] = 1'b0; idle(3);
    readCheck("R3 low level pending", 9'h108, 32'h40);
    readCheck("R11 raw inputs", 9'h100, 32'hFFFF_FF9F);
    srcIn[6] = 1'b1; idle(3);
    readCheck("R3 low level released", 9'h108, 32'h0);
  endtask

  task automatic t_edge;
    srcIn[8] = 1'b0;
    busWrite(9'h020, 32'hC3);
    idle(3);
    readCheck("R4 rising no edge yet", 9'h108, 32'h0);
    srcIn[8] = 1'b1; idle(3);
    readCheck("R4 rising latched", 9'h108, 32'h100);
    srcIn[8] = 1'b0; idle(3);
    readCheck("R4 rising held after input falls", 9'h108, 32'h100);
    busWrite(9'h12C, 32'h100);
    readCheck("R10 clear command", 9'h108, 32'h0);
    busWrite(9'h024, 32'h81);
    srcIn[9] = 1'b0; idle(3);
    readCheck("R4 falling latched", 9'h108, 32'h200);
    srcIn[9] = 1'b1; idle(3);
    busWrite(9'h12C, 32'h200);
    readCheck("R10 clear falling latch", 9'h108, 32'h0);
  endtask

  task automatic t_mask_irq;
    busWrite(9'h128, 32'h200);
    readCheck("R10 set command", 9'h108, 32'h200);
    idle(3);
    check("R5 masked source keeps irqN high", {31'b0, irqN}, 32'd1);
    readCheck("R5 active empty while masked", 9'h104, 32'h0);
    busWrite(9'h120, 32'h200);
    idle(3);
    readCheck("R5 enable reg", 9'h114, 32'h200);
    readCheck("R5 active status", 9'h104, 32'h200);
    check("R6 irqN asserted", {31'b0, irqN}, 32'd0);
    readCheck("R11 out status asserted", 9'h118, 32'h1);
  endtask

  task automatic t_vector;
    busWrite(9'h128, 32'h100);
    busWrite(9'h120, 32'h100);
    idle(2);
    readCheck("R7 src9 pri1 beats src8 pri3", 9'h10C, 32'd36);
    check("R8 irqN released after vector read", {31'b0, irqN}, 32'd1);
    readCheck("R7 current source", 9'h110, 32'd9);
    readCheck("R9 winner latch cleared", 9'h108, 32'h100);
    idle(5);
    check("R8 quiet until end of service", {31'b0, irqN}, 32'd1);
    busWrite(9'h130, 32'h0);
    idle(3);
    check("R6 reasserted after end of service", {31'b0, irqN}, 32'd0);
    readCheck("R7 next winner src8", 9'h10C, 32'd32);
    readCheck("R9 src8 latch cleared", 9'h108, 32'h0);
    busWrite(9'h130, 32'h0);
    idle(3);
    check("R6 idle with nothing pending", {31'b0, irqN}, 32'd1);
  endtask

  task automatic t_tie;
    busWrite(9'h030, 32'hC2);
    busWrite(9'h028, 32'hC2);
    busWrite(9'h02C, 32'hC5);
    busWrite(9'h128, 32'h1C00);
    busWrite(9'h120, 32'h1C00);
    idle(3);
    readCheck("R7 tie lowest index", 9'h10C, 32'd40);
    busWrite(9'h130, 32'h0);
    idle(3);
    readCheck("R7 pri2 beats pri5", 9'h10C, 32'd48);
    busWrite(9'h130, 32'h0);
    idle(3);
    readCheck("R7 last remaining", 9'h10C, 32'd44);
    busWrite(9'h130, 32'h0);
  endtask

  task automatic t_mask_all;
    busWrite(9'h128, 32'h400);
    idle(3);
    check("R6 src10 asserts", {31'b0, irqN}, 32'd0);
    busWrite(9'h124, 32'hFFFF_FFFF);
    idle(3);
    check("R5 disable all releases irqN", {31'b0, irqN}, 32'd1);
    readCheck("R5 enable reg cleared", 9'h114, 32'h0);
    readCheck("R7 vector zero when nothing active", 9'h10C, 32'h0);
    busWrite(9'h130, 32'h0);
    readCheck("R5 pending kept through mask", 9'h108, 32'h400);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset;
    t_config;
    t_level;
    t_edge;
    t_mask_irq;
    t_vector;
    t_tie;
    t_mask_all;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule